// File: doc/BRIEF.md
# Startup Mode Strap and Calibration Sequencer

This block brings up the digital side of a data converter. Once the internal power-on reset is released, it counts master clock cycles and samples a shared data pin at one fixed count. A pulled-up pin selects control-port operation. A low pin selects stand-alone operation. A second strap pin is sampled on the same edge and chooses the style of the serial control protocol. The decision is latched and holds until the next power-on reset.

In control-port operation, the control clock and data inputs are gated to zero until the external pull-up on the strap pin is seen released. After that the gate stays open.

A calibration request passes through a synchronizer, so every device that shares the master clock starts on the same rising edge. Calibration is modelled as a busy interval of fixed length. At the end of the interval, a one-cycle frame sync pulse restarts the downstream frame divider on all devices together.

Top module: `boot_strap_cal_seq`

## Requirements
- R1: While `por_n` is low, every flag and pulse output is 0, and this takes effect asynchronously. The release of `por_n` reaches the logic through a chain of SYNC_STAGES flops (default 2).
- R2: The strap is sampled at rising edge number SYNC_STAGES+STRAP_CYCLES (default 252), counting the first edge at which `por_n` is high as edge 1. `mode_valid` is 0 after the edge before that one and 1 after it.
- R3: At that edge, `strap_pin` = 1 sets `ctrl_mode` = 1 (control port) and `strap_pin` = 0 sets `ctrl_mode` = 0 (stand-alone). On the same edge, `proto_pin` is copied into `proto_i2s`, where 1 means two-wire style.
- R4: Once `mode_valid` is 1, later changes on `strap_pin` and `proto_pin` leave `ctrl_mode` and `proto_i2s` unchanged until `por_n` is asserted again.
- R5: `port_en` rises at the first edge after the latching edge at which `ctrl_mode` is 1 and `strap_pin` is 0, and it then stays 1. While `port_en` is 0, `ctl_clk_out` and `ctl_din_out` are 0. While it is 1, they follow `ctl_clk_in` and `ctl_din_in`. In stand-alone mode `port_en` never rises.
- R6: A 0-to-1 change of `cal_req` is retimed. `cal_busy` and a one-cycle `cal_start` rise at the third consecutive rising edge that samples `cal_req` high.
- R7: `cal_busy` stays high for exactly CAL_CYCLES cycles (default 16).
- R8: A rising `cal_req` that is detected while `cal_busy` is high is ignored, and the busy interval is not extended.
- R9: `frame_sync` is high for one cycle, in the first cycle after `cal_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mclk | input | 1 | Master clock |
| por_n | input | 1 | Internal power-on reset, active low, asynchronous |
| strap_pin | input | 1 | Level sensed on the shared data pin (mode strap) |
| proto_pin | input | 1 | Protocol strap level |
| ctl_clk_in | input | 1 | Raw control interface clock |
| ctl_din_in | input | 1 | Raw control interface data |
| cal_req | input | 1 | Calibration request, unsynchronized |
| mode_valid | output | 1 | Strap decision has been latched |
| ctrl_mode | output | 1 | 1 = control-port mode, 0 = stand-alone |
| proto_i2s | output | 1 | Latched protocol strap |
| port_en | output | 1 | Control port gate open |
| ctl_clk_out | output | 1 | Gated control clock |
| ctl_din_out | output | 1 | Gated control data |
| cal_busy | output | 1 | Calibration interval active |
| cal_start | output | 1 | One-cycle pulse at calibration launch |
| frame_sync | output | 1 | One-cycle pulse restarting the frame divider |

## Verification
The hardest case to reach is proving that the strap is sampled on exactly one edge and not on a neighbouring one. The bench counts edges from the release of reset and drives the strap pin high for that single edge only. It then holds the pin high afterwards, so a late sampling point shows up through `mode_valid` and an early one shows up through `ctrl_mode`.

A second hard case is a request edge that arrives during calibration. The bench lowers and raises `cal_req` in the middle of the busy interval and then checks that the interval ends on the original cycle.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic {
    OPM_STANDALONE = 1'b0,
    OPM_CTRLPORT   = 1'b1
  } opmode_e;

  typedef struct packed {
    opmode_e mode;
    logic    proto_i2s;
  } strap_t;
endpackage

// File: rtl/bss_rst_sync.sv
module bss_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_nxt;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/bss_strap_latch.sv
module bss_strap_latch
  import bss_pkg::*;
#(
  parameter int STRAP_CYCLES = 250
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   strap_pin,
  input  logic   proto_pin,
  output strap_t strap_o,
  output logic   valid_o,
  output logic   port_en_o
);
  localparam int CNT_W = $clog2(STRAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STRAP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             valid_q, valid_nxt;
  logic             port_q, port_nxt;
  strap_t           strap_q, strap_nxt;
  logic             cnt_en, strap_en;

  always_comb begin
    cnt_nxt   = cnt_q;
    valid_nxt = valid_q;
    port_nxt  = port_q;
    strap_nxt = strap_q;
    cnt_en    = 1'b0;
    strap_en  = 1'b0;
    if (!valid_q) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        valid_nxt           = 1'b1;
        strap_en            = 1'b1;
        strap_nxt.mode      = opmode_e'(strap_pin);
        strap_nxt.proto_i2s = proto_pin;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end else if (strap_q.mode == OPM_CTRLPORT && !strap_pin) begin
      port_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
      port_q  <= 1'b0;
      strap_q <= '{mode: OPM_STANDALONE, proto_i2s: 1'b0};
    end else begin
      if (cnt_en)   cnt_q   <= cnt_nxt;
      if (strap_en) strap_q <= strap_nxt;
      valid_q <= valid_nxt;
      port_q  <= port_nxt;
    end
  end

  assign strap_o   = strap_q;
  assign valid_o   = valid_q;
  assign port_en_o = port_q;
endmodule

// File: rtl/bss_cal_seq.sv
module bss_cal_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int CAL_CYCLES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_req,
  output logic busy_o,
  output logic start_o,
  output logic fsync_o
);
  localparam int CAL_W = $clog2(CAL_CYCLES + 1);
  localparam logic [CAL_W-1:0] LOAD = CAL_W'(CAL_CYCLES - 1);

  logic [SYNC_STAGES-1:0] req_sync_q, req_sync_nxt;
  logic                   req_dly_q;
  logic                   req_rise;
  logic [CAL_W-1:0]       cnt_q, cnt_nxt;
  logic                   busy_q, busy_nxt;
  logic                   start_q, start_nxt;
  logic                   fsync_q, fsync_nxt;
  logic                   cnt_en;

  always_comb begin
    req_sync_nxt = {req_sync_q[SYNC_STAGES-2:0], cal_req};
    req_rise     = req_sync_q[SYNC_STAGES-1] & ~req_dly_q;
    cnt_nxt      = cnt_q;
    busy_nxt     = busy_q;
    start_nxt    = 1'b0;
    fsync_nxt    = 1'b0;
    cnt_en       = 1'b0;
    if (busy_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) begin
        busy_nxt  = 1'b0;
        fsync_nxt = 1'b1;
      end else begin
        cnt_nxt = cnt_q - 1'b1;
      end
    end else if (req_rise) begin
      cnt_en    = 1'b1;
      busy_nxt  = 1'b1;
      start_nxt = 1'b1;
      cnt_nxt   = LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sync_q <= '0;
      req_dly_q  <= 1'b0;
      cnt_q      <= '0;
      busy_q     <= 1'b0;
      start_q    <= 1'b0;
      fsync_q    <= 1'b0;
    end else begin
      req_sync_q <= req_sync_nxt;
      req_dly_q  <= req_sync_q[SYNC_STAGES-1];
      if (cnt_en) cnt_q <= cnt_nxt;
      busy_q     <= busy_nxt;
      start_q    <= start_nxt;
      fsync_q    <= fsync_nxt;
    end
  end

  assign busy_o  = busy_q;
  assign start_o = start_q;
  assign fsync_o = fsync_q;
endmodule

// File: rtl/boot_strap_cal_seq.sv
module boot_strap_cal_seq
  import bss_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int STRAP_CYCLES = 250,
  parameter int CAL_CYCLES   = 16
) (
  input  logic clk_mclk,
  input  logic por_n,
  input  logic strap_pin,
  input  logic proto_pin,
  input  logic ctl_clk_in,
  input  logic ctl_din_in,
  input  logic cal_req,
  output logic mode_valid,
  output logic ctrl_mode,
  output logic proto_i2s,
  output logic port_en,
  output logic ctl_clk_out,
  output logic ctl_din_out,
  output logic cal_busy,
  output logic cal_start,
  output logic frame_sync
);
  logic   rst_n_int;
  strap_t strap_w;

  bss_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk_mclk),
    .arst_n  (por_n),
    .rst_n_o (rst_n_int)
  );

  bss_strap_latch #(.STRAP_CYCLES(STRAP_CYCLES)) u_strap (
    .clk       (clk_mclk),
    .rst_n     (rst_n_int),
    .strap_pin (strap_pin),
    .proto_pin (proto_pin),
    .strap_o   (strap_w),
    .valid_o   (mode_valid),
    .port_en_o (port_en)
  );

  bss_cal_seq #(.SYNC_STAGES(SYNC_STAGES), .CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk     (clk_mclk),
    .rst_n   (rst_n_int),
    .cal_req (cal_req),
    .busy_o  (cal_busy),
    .start_o (cal_start),
    .fsync_o (frame_sync)
  );

  assign ctrl_mode   = (strap_w.mode == OPM_CTRLPORT);
  assign proto_i2s   = strap_w.proto_i2s;
  assign ctl_clk_out = ctl_clk_in & port_en;
  assign ctl_din_out = ctl_din_in & port_en;
endmodule

// File: rtl/boot_strap_cal_seq_chk.sv
module boot_strap_cal_seq_chk #(
  parameter int CAL_CYCLES = 16
) (
  input logic clk_mclk,
  input logic por_n,
  input logic mode_valid,
  input logic ctrl_mode,
  input logic proto_i2s,
  input logic port_en,
  input logic cal_busy,
  input logic cal_start,
  input logic frame_sync
);
  int busy_len_q;

  always_ff @(posedge clk_mclk or negedge por_n) begin
    if (!por_n)        busy_len_q <= 0;
    else if (cal_busy) busy_len_q <= busy_len_q + 1;
    else               busy_len_q <= 0;
  end

  AST_MODE_HELD: assert property (@(posedge clk_mclk) disable iff (!por_n)
    mode_valid |=> mode_valid && $stable(ctrl_mode) && $stable(proto_i2s)); // R4
  AST_PORT_NEEDS_CTRL: assert property (@(posedge clk_mclk) disable iff (!por_n)
    port_en |-> (mode_valid && ctrl_mode)); // R5
  AST_PORT_STICKY: assert property (@(posedge clk_mclk) disable iff (!por_n)
    port_en |=> port_en); // R5
  AST_START_THEN_BUSY: assert property (@(posedge clk_mclk) disable iff (!por_n)
    cal_start |=> (cal_busy && !cal_start)); // R6
  AST_BUSY_LENGTH: assert property (@(posedge clk_mclk) disable iff (!por_n)
    $fell(cal_busy) |-> (busy_len_q == CAL_CYCLES)); // R7
  AST_NO_RESTART_BUSY: assert property (@(posedge clk_mclk) disable iff (!por_n)
    (cal_busy && !cal_start) |=> !cal_start); // R8
  AST_SYNC_AFTER_BUSY: assert property (@(posedge clk_mclk) disable iff (!por_n)
    frame_sync |-> (!cal_busy && $past(cal_busy))); // R9
  AST_PULSES_APART: assert property (@(posedge clk_mclk) disable iff (!por_n)
    $onehot0({cal_start, frame_sync})); // R9
endmodule

bind boot_strap_cal_seq boot_strap_cal_seq_chk #(.CAL_CYCLES(CAL_CYCLES)) u_chk (
  .clk_mclk   (clk_mclk),
  .por_n      (por_n),
  .mode_valid (mode_valid),
  .ctrl_mode  (ctrl_mode),
  .proto_i2s  (proto_i2s),
  .port_en    (port_en),
  .cal_busy   (cal_busy),
  .cal_start  (cal_start),
  .frame_sync (frame_sync)
);

// File: tb/boot_strap_cal_seq_tb.sv
module boot_strap_cal_seq_tb;
  localparam int SYNC = 2;
  localparam int NSTRAP = 250;
  localparam int NCAL = 16;

  logic clk_mclk = 1'b0;
  logic por_n = 1'b0;
  logic strap_pin = 1'b0, proto_pin = 1'b0;
  logic ctl_clk_in = 1'b0, ctl_din_in = 1'b0, cal_req = 1'b0;
  logic mode_valid, ctrl_mode, proto_i2s, port_en;
  logic ctl_clk_out, ctl_din_out, cal_busy, cal_start, frame_sync;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct {
    int    cyc;
    int    sig;
    logic  val;
    string req;
  } exp_t;
  exp_t sb_q[$];

  boot_strap_cal_seq #(.SYNC_STAGES(SYNC), .STRAP_CYCLES(NSTRAP), .CAL_CYCLES(NCAL)) u_dut (
    .clk_mclk(clk_mclk), .por_n(por_n), .strap_pin(strap_pin), .proto_pin(proto_pin),
    .ctl_clk_in(ctl_clk_in), .ctl_din_in(ctl_din_in), .cal_req(cal_req),
    .mode_valid(mode_valid), .ctrl_mode(ctrl_mode), .proto_i2s(proto_i2s),
    .port_en(port_en), .ctl_clk_out(ctl_clk_out), .ctl_din_out(ctl_din_out),
    .cal_busy(cal_busy), .cal_start(cal_start), .frame_sync(frame_sync)
  );

  always #5 clk_mclk = ~clk_mclk;
  always @(posedge clk_mclk) cyc <= cyc + 1;

  function automatic logic get_sig(int s);
    case (s)
      0: return mode_valid;
      1: return ctrl_mode;
      2: return proto_i2s;
      3: return port_en;
      4: return cal_busy;
      5: return cal_start;
      6: return frame_sync;
      7: return ctl_clk_out;
      default: return ctl_din_out;
    endcase
  endfunction

  task automatic push(int c, int s, logic v, string r);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.req = r;
    sb_q.push_back(e);
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk_mclk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: pops expectations due at this cycle
  initial begin
    forever begin
      @(negedge clk_mclk);
      while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        n_cmp++;
        if (e.cyc != cyc || get_sig(e.sig) !== e.val) begin
          n_bad++;
          $display("FAIL %s: cycle %0d signal %0d actual %b expected %b",
                   e.req, cyc, e.sig, get_sig(e.sig), e.val);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(20000 * 10);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    int c0, e0, c1, r0, e2;
    ctl_clk_in = 1'b1;
    // R1 reset state
    for (int s = 0; s < 7; s++) push(3, s, 1'b0, "R1");
    wait_cyc(4);

    // Phase A: control-port strap, sampled on one exact edge
    por_n = 1'b1;
    c0 = cyc;
    e0 = c0 + SYNC + NSTRAP;
    push(e0 - 1, 0, 1'b0, "R2");
    push(e0, 0, 1'b1, "R2");
    push(e0, 1, 1'b1, "R3");
    push(e0, 2, 1'b1, "R3");
    push(e0, 3, 1'b0, "R5");
    push(e0 + 3, 3, 1'b0, "R5");
    push(e0 + 3, 7, 1'b0, "R5");
    push(e0 + 4, 3, 1'b1, "R5");
    push(e0 + 4, 7, 1'b1, "R5");
    push(e0 + 4, 1, 1'b1, "R4");
    push(e0 + 7, 1, 1'b1, "R4");
    push(e0 + 7, 2, 1'b1, "R4");
    push(e0 + 7, 3, 1'b1, "R5");
    wait_cyc(e0 - 1);
    strap_pin = 1'b1; proto_pin = 1'b1;
    wait_cyc(e0);
    proto_pin = 1'b0;
    wait_cyc(e0 + 3);
    strap_pin = 1'b0;
    wait_cyc(e0 + 5);
    strap_pin = 1'b1;
    wait_cyc(e0 + 8);

    // Phase B: calibration, with a request edge during busy
    c1 = cyc;
    push(c1 + 2, 4, 1'b0, "R6");
    push(c1 + 3, 4, 1'b1, "R6");
    push(c1 + 3, 5, 1'b1, "R6");
    push(c1 + 4, 5, 1'b0, "R6");
    push(c1 + 4, 4, 1'b1, "R7");
    push(c1 + 2 + NCAL, 4, 1'b1, "R7");
    push(c1 + 3 + NCAL, 4, 1'b0, "R7");
    push(c1 + 3 + NCAL, 6, 1'b1, "R9");
    push(c1 + 4 + NCAL, 6, 1'b0, "R9");
    push(c1 + 4 + NCAL, 5, 1'b0, "R8");
    push(c1 + 6 + NCAL, 4, 1'b0, "R8");
    cal_req = 1'b1;
    wait_cyc(c1 + 5);
    cal_req = 1'b0;
    wait_cyc(c1 + 7);
    cal_req = 1'b1;
    wait_cyc(c1 + 12);
    cal_req = 1'b0;
    wait_cyc(c1 + NCAL + 10);

    // Phase C: asynchronous reset, then stand-alone strap
    r0 = cyc;
    for (int s = 0; s < 7; s++) push(r0 + 1, s, 1'b0, "R1");
    por_n = 1'b0;
    wait_cyc(r0 + 3);
    strap_pin = 1'b0; proto_pin = 1'b0;
    por_n = 1'b1;
    e2 = cyc + SYNC + NSTRAP;
    push(e2 - 1, 0, 1'b0, "R2");
    push(e2, 0, 1'b1, "R2");
    push(e2, 1, 1'b0, "R3");
    push(e2, 2, 1'b0, "R3");
    push(e2 + 3, 1, 1'b0, "R4");
    push(e2 + 3, 2, 1'b0, "R4");
    push(e2 + 3, 3, 1'b0, "R5");
    push(e2 + 3, 8, 1'b0, "R5");
    push(e2 + 8, 3, 1'b0, "R5");
    push(e2 + 8, 8, 1'b0, "R5");
    wait_cyc(e2);
    strap_pin = 1'b1; proto_pin = 1'b1; ctl_din_in = 1'b1;
    wait_cyc(e2 + 5);
    strap_pin = 1'b0;
    wait_cyc(e2 + 10);

    if (sb_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    finished = 1;
    summary();
  end
endmodule